// File: doc/BRIEF.md
# Dual-Pipe In-Order Issue Pairing Stage

This block sits at the issue point of a two-pipeline in-order SIMD core. Each cycle the fetch side may offer a pair of instructions taken from a doubleword-aligned address. Slot 0 holds the instruction at the even word address and slot 1 the one at the odd word address. Each slot arrives with a valid bit, a predecoded target pipe and a flag that marks a local-store access. The stage decides whether the pair can leave together, must be split into two single issues, or has to wait. It then drives the even-pipe and odd-pipe issue ports after a fixed issue latency.

Two conditions hold instructions back. An external operand-hazard stall freezes the oldest unissued instruction and everything behind it. A local-store access can only leave in a cycle where the local store reports a free access slot. The stage holds one pair at a time and takes the next pair in the same cycle that the last pending slot of the current pair issues. Instructions are 128 bits wide, four 32-bit words, and pass through unchanged.

Top module: `pair_issue`

## Requirements
- R1: `pair_ready` is high exactly when every valid slot of the held pair has already issued or issues in the current cycle. A pair is captured at a clock edge where `pair_valid` and `pair_ready` are both high.
- R2: Pipe code 0 means even pipe and 1 means odd pipe. Both slots of a held pair issue in the same cycle when slot 0 targets pipe 0, slot 1 targets pipe 1, the stall is low, each access-flagged slot sees `ls_avail` high, and the two slots are not both access-flagged.
- R3: When a pair with two valid slots cannot go out together, slot 0 issues alone to the port of its own target pipe. Slot 1 is re-evaluated in the next cycles as a single instruction and goes to the port of its own target pipe.
- R4: Program order holds: slot 1 of a pair never reaches a port before slot 0 of the same pair, and nothing reaches a port that was not accepted.
- R5: When slot 0 of an accepted pair is invalid, only slot 1 issues, as a single instruction to its target pipe.
- R6: An access-flagged instruction issues only in a cycle where `ls_avail` is high. At most one such instruction issues per cycle, and its port carries a high memory flag.
- R7: A slot 0 that is held for a local-store cycle also holds slot 1 of the same pair, even when slot 1 needs no access and targets the other pipe.
- R8: While `hz_stall` is high, no instruction issues in that cycle.
- R9: An instruction that issues in the first cycle after its pair is captured appears on its port 3 clock edges after the capturing edge. Each extra cycle spent waiting adds exactly one edge.
- R10: The 128-bit instruction word appears on the port unchanged.
- R11: Out of reset, both issue ports are invalid and `pair_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_valid | input | 1 | Fetch offers a pair |
| pair_ready | output | 1 | Stage takes the offered pair at this edge |
| s0_vld | input | 1 | Slot 0 (even word address) holds an instruction |
| s0_pipe | input | 1 | Slot 0 target pipe, 0 even, 1 odd |
| s0_mem | input | 1 | Slot 0 is a local-store access |
| s0_insn | input | 128 | Slot 0 instruction |
| s1_vld | input | 1 | Slot 1 (odd word address) holds an instruction |
| s1_pipe | input | 1 | Slot 1 target pipe, 0 even, 1 odd |
| s1_mem | input | 1 | Slot 1 is a local-store access |
| s1_insn | input | 128 | Slot 1 instruction |
| ls_avail | input | 1 | Local store has a free access cycle now |
| hz_stall | input | 1 | Operand hazard, hold all issue this cycle |
| ev_vld | output | 1 | Even-pipe issue port valid |
| ev_mem | output | 1 | Even-pipe instruction is a local-store access |
| ev_insn | output | 128 | Even-pipe instruction |
| od_vld | output | 1 | Odd-pipe issue port valid |
| od_mem | output | 1 | Odd-pipe instruction is a local-store access |
| od_insn | output | 128 | Odd-pipe instruction |

## Verification
`pair_ready` is combinational on the held pair, `hz_stall` and `ls_avail`, so the bench compares it in the same cycle, one nanosecond after it drives the inputs. An issue decision formed in a cycle shows on the ports three clock edges later. The bench files each expected port value three cycles ahead of the cycle whose inputs produced it, and compares the ports at the falling edge of that later cycle. Pairs, stall and access-slot patterns are swept first over all 64 slot combinations, then with pseudo-random stalls, access slots and fetch gaps.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;

   localparam int NPIPE = 2;

   typedef enum logic {
      PIPE_EVEN = 1'b0,
      PIPE_ODD  = 1'b1
   } pipe_e;

   typedef struct packed {
      pipe_e pipe;
      logic  mem;
   } slot_attr_t;

endpackage

// File: rtl/pair_issue_hold.sv
module pair_issue_hold
   import pair_issue_pkg::*;
#(
   parameter int INSN_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              vld0_in,
   input  logic              vld1_in,
   input  slot_attr_t        attr0_in,
   input  slot_attr_t        attr1_in,
   input  logic [INSN_W-1:0] insn0_in,
   input  logic [INSN_W-1:0] insn1_in,
   input  logic              go0,
   input  logic              go1,
   output logic              pend0,
   output logic              pend1,
   output slot_attr_t        attr0,
   output slot_attr_t        attr1,
   output logic [INSN_W-1:0] insn0,
   output logic [INSN_W-1:0] insn1
);

   // pending flags: a new pair replaces the old one, issue clears a slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend0 <= 1'b0;
         pend1 <= 1'b0;
      end else if (load) begin
         pend0 <= vld0_in;
         pend1 <= vld1_in;
      end else begin
         if (go0) pend0 <= 1'b0;
         if (go1) pend1 <= 1'b0;
      end
   end

   // payload carries no reset, it is qualified by the pending flags
   always_ff @(posedge clk) begin
      if (load) begin
         attr0 <= attr0_in;
         attr1 <= attr1_in;
         insn0 <= insn0_in;
         insn1 <= insn1_in;
      end
   end

endmodule

// File: rtl/pair_issue_rules.sv
module pair_issue_rules
   import pair_issue_pkg::*;
(
   input  logic       pend0,
   input  logic       pend1,
   input  slot_attr_t attr0,
   input  slot_attr_t attr1,
   input  logic       stall,
   input  logic       ls_avail,
   output logic       go0,
   output logic       go1,
   output logic       all_done
);

   logic ready0;
   logic ready1;
   logic slot_fit;
   logic mem_clash;

   always_comb begin
      // a slot is ready on its own when no stall and, for an access, a free slot
      ready0    = !stall && (!attr0.mem || ls_avail);
      ready1    = !stall && (!attr1.mem || ls_avail);
      // pairing depends on slot position, one local-store cycle per clock
      slot_fit  = (attr0.pipe == PIPE_EVEN) && (attr1.pipe == PIPE_ODD);
      mem_clash = attr0.mem && attr1.mem;

      go0 = pend0 && ready0;
      if (pend0)
         go1 = pend1 && ready1 && go0 && slot_fit && !mem_clash;
      else
         go1 = pend1 && ready1;

      all_done = (!pend0 || go0) && (!pend1 || go1);
   end

endmodule

// File: rtl/pair_issue_route.sv
module pair_issue_route
   import pair_issue_pkg::*;
#(
   parameter int INSN_W = 128
) (
   input  logic                          go0,
   input  logic                          go1,
   input  slot_attr_t                    attr0,
   input  slot_attr_t                    attr1,
   input  logic [INSN_W-1:0]             insn0,
   input  logic [INSN_W-1:0]             insn1,
   output logic [NPIPE-1:0]              vld,
   output logic [NPIPE-1:0]              mem,
   output logic [NPIPE-1:0][INSN_W-1:0]  insn
);

   // one steering slice per pipe; index 0 is the even pipe
   for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
      logic take0;
      logic take1;

      assign take0   = go0 && (attr0.pipe == pipe_e'(1'(p)));
      assign take1   = go1 && (attr1.pipe == pipe_e'(1'(p)));
      assign vld[p]  = take0 || take1;
      assign mem[p]  = (take0 && attr0.mem) || (take1 && attr1.mem);
      assign insn[p] = take0 ? insn0 : insn1;
   end

endmodule

// File: rtl/pair_issue_delay.sv
module pair_issue_delay #(
   parameter int FLAG_W = 4,
   parameter int DATA_W = 256,
   parameter int LAT    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] flag_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [FLAG_W-1:0] flag_out,
   output logic [DATA_W-1:0] data_out
);

   logic [FLAG_W-1:0] f_q [LAT];
   logic [DATA_W-1:0] d_q [LAT];

   if (LAT == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) f_q[0] <= '0;
         else        f_q[0] <= flag_in;
      end
      always_ff @(posedge clk) d_q[0] <= data_in;
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < LAT; s++) f_q[s] <= '0;
         end else begin
            f_q[0] <= flag_in;
            for (int s = 1; s < LAT; s++) f_q[s] <= f_q[s-1];
         end
      end
      always_ff @(posedge clk) begin
         d_q[0] <= data_in;
         for (int s = 1; s < LAT; s++) d_q[s] <= d_q[s-1];
      end
   end

   assign flag_out = f_q[LAT-1];
   assign data_out = d_q[LAT-1];

endmodule

// File: rtl/pair_issue.sv
module pair_issue
   import pair_issue_pkg::*;
#(
   parameter int INSN_W    = 128,
   parameter int WORD_W    = 32,
   parameter int ISSUE_LAT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pair_valid,
   output logic              pair_ready,
   input  logic              s0_vld,
   input  logic              s0_pipe,
   input  logic              s0_mem,
   input  logic [INSN_W-1:0] s0_insn,
   input  logic              s1_vld,
   input  logic              s1_pipe,
   input  logic              s1_mem,
   input  logic [INSN_W-1:0] s1_insn,
   input  logic              ls_avail,
   input  logic              hz_stall,
   output logic              ev_vld,
   output logic              ev_mem,
   output logic [INSN_W-1:0] ev_insn,
   output logic              od_vld,
   output logic              od_mem,
   output logic [INSN_W-1:0] od_insn
);

   localparam int WORDS  = INSN_W / WORD_W;
   localparam int FLAG_W = 2 * NPIPE;
   localparam int DATA_W = NPIPE * INSN_W;

   if (WORDS < 1 || WORDS * WORD_W != INSN_W) begin : g_bad_width
      $error("pair_issue: INSN_W must be a whole number of WORD_W words");
   end
   if (ISSUE_LAT < 1) begin : g_bad_lat
      $error("pair_issue: ISSUE_LAT must be at least one");
   end

   slot_attr_t        a0_in;
   slot_attr_t        a1_in;
   slot_attr_t        a0;
   slot_attr_t        a1;
   logic              load;
   logic              pend0;
   logic              pend1;
   logic              go0;
   logic              go1;
   logic              all_done;
   logic [INSN_W-1:0] h_insn0;
   logic [INSN_W-1:0] h_insn1;

   logic [NPIPE-1:0]             r_vld;
   logic [NPIPE-1:0]             r_mem;
   logic [NPIPE-1:0][INSN_W-1:0] r_insn;
   logic [FLAG_W-1:0]            q_flag;
   logic [DATA_W-1:0]            q_data;

   assign a0_in.pipe = pipe_e'(s0_pipe);
   assign a0_in.mem  = s0_mem;
   assign a1_in.pipe = pipe_e'(s1_pipe);
   assign a1_in.mem  = s1_mem;

   assign pair_ready = all_done;
   assign load       = pair_valid && all_done;

   pair_issue_hold #(.INSN_W(INSN_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .vld0_in  (s0_vld),
      .vld1_in  (s1_vld),
      .attr0_in (a0_in),
      .attr1_in (a1_in),
      .insn0_in (s0_insn),
      .insn1_in (s1_insn),
      .go0      (go0),
      .go1      (go1),
      .pend0    (pend0),
      .pend1    (pend1),
      .attr0    (a0),
      .attr1    (a1),
      .insn0    (h_insn0),
      .insn1    (h_insn1)
   );

   pair_issue_rules u_rules (
      .pend0    (pend0),
      .pend1    (pend1),
      .attr0    (a0),
      .attr1    (a1),
      .stall    (hz_stall),
      .ls_avail (ls_avail),
      .go0      (go0),
      .go1      (go1),
      .all_done (all_done)
   );

   pair_issue_route #(.INSN_W(INSN_W)) u_route (
      .go0   (go0),
      .go1   (go1),
      .attr0 (a0),
      .attr1 (a1),
      .insn0 (h_insn0),
      .insn1 (h_insn1),
      .vld   (r_vld),
      .mem   (r_mem),
      .insn  (r_insn)
   );

   pair_issue_delay #(
      .FLAG_W (FLAG_W),
      .DATA_W (DATA_W),
      .LAT    (ISSUE_LAT)
   ) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .flag_in  ({r_mem, r_vld}),
      .data_in  (r_insn),
      .flag_out (q_flag),
      .data_out (q_data)
   );

   assign ev_vld  = q_flag[0];
   assign od_vld  = q_flag[1];
   assign ev_mem  = q_flag[NPIPE];
   assign od_mem  = q_flag[NPIPE+1];
   assign ev_insn = q_data[INSN_W-1:0];
   assign od_insn = q_data[2*INSN_W-1:INSN_W];

endmodule

// File: rtl/pair_issue_chk.sv
module pair_issue_chk #(
   parameter int LAT = 3
) (
   input logic clk,
   input logic rst_n,
   input logic pair_valid,
   input logic pair_ready,
   input logic s0_vld,
   input logic s1_vld,
   input logic ls_avail,
   input logic hz_stall,
   input logic ev_vld,
   input logic ev_mem,
   input logic od_vld,
   input logic od_mem
);

   logic [LAT-1:0] stall_h;
   logic [LAT-1:0] avail_h;
   logic [31:0]    acc_n;
   logic [31:0]    out_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stall_h <= '0;
         avail_h <= '0;
         acc_n   <= '0;
         out_n   <= '0;
      end else begin
         stall_h <= (stall_h << 1) | LAT'(hz_stall);
         avail_h <= (avail_h << 1) | LAT'(ls_avail);
         if (pair_valid && pair_ready)
            acc_n <= acc_n + 32'(s0_vld) + 32'(s1_vld);
         out_n <= out_n + 32'(ev_vld) + 32'(od_vld);
      end
   end

   AST_ONE_MEM_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) !(ev_mem && od_mem)); // R6
   AST_MEM_HAD_SLOT: assert property (@(posedge clk) disable iff (!rst_n) ((ev_vld && ev_mem) || (od_vld && od_mem)) |-> avail_h[LAT-1]); // R6
   AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) stall_h[LAT-1] |-> (!ev_vld && !od_vld)); // R8
   AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n) out_n <= acc_n); // R4

endmodule

bind pair_issue pair_issue_chk #(.LAT(ISSUE_LAT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pair_valid (pair_valid),
   .pair_ready (pair_ready),
   .s0_vld     (s0_vld),
   .s1_vld     (s1_vld),
   .ls_avail   (ls_avail),
   .hz_stall   (hz_stall),
   .ev_vld     (ev_vld),
   .ev_mem     (ev_mem),
   .od_vld     (od_vld),
   .od_mem     (od_mem)
);

// File: tb/tb_pair_issue.sv
`timescale 1ns/1ps
module tb_pair_issue;

   localparam int W    = 128;
   localparam int LAT  = 3;
   localparam int NCYC = 3000;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         pair_valid;
   logic         pair_ready;
   logic         s0_vld, s0_pipe, s0_mem;
   logic         s1_vld, s1_pipe, s1_mem;
   logic [W-1:0] s0_insn, s1_insn;
   logic         ls_avail, hz_stall;
   logic         ev_vld, ev_mem, od_vld, od_mem;
   logic [W-1:0] ev_insn, od_insn;

   always #4 clk = ~clk;

   pair_issue #(.INSN_W(W), .WORD_W(32), .ISSUE_LAT(LAT)) dut (
      .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .pair_ready(pair_ready),
      .s0_vld(s0_vld), .s0_pipe(s0_pipe), .s0_mem(s0_mem), .s0_insn(s0_insn),
      .s1_vld(s1_vld), .s1_pipe(s1_pipe), .s1_mem(s1_mem), .s1_insn(s1_insn),
      .ls_avail(ls_avail), .hz_stall(hz_stall),
      .ev_vld(ev_vld), .ev_mem(ev_mem), .ev_insn(ev_insn),
      .od_vld(od_vld), .od_mem(od_mem), .od_insn(od_insn)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic  x_ev_v [NCYC+LAT+1];
   logic  x_ev_m [NCYC+LAT+1];
   int    x_ev_t [NCYC+LAT+1];
   logic  x_od_v [NCYC+LAT+1];
   logic  x_od_m [NCYC+LAT+1];
   int    x_od_t [NCYC+LAT+1];
   string x_req  [NCYC+LAT+1];

   function automatic logic [W-1:0] mk(input int tag);
      logic [31:0] t;
      t = 32'(tag);
      return {~t, t + 32'd7, t ^ 32'h5a5a_c3c3, t};
   endfunction

   function automatic logic [31:0] nx(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic port_chk(input int c);
      chk(ev_vld === x_ev_v[c], x_req[c], "even valid", longint'(ev_vld), longint'(x_ev_v[c]));
      chk(od_vld === x_od_v[c], x_req[c], "odd valid", longint'(od_vld), longint'(x_od_v[c]));
      if (ev_vld && x_ev_v[c]) begin
         chk(ev_insn === mk(x_ev_t[c]), "R10", "even insn low word", longint'(ev_insn[31:0]), longint'(x_ev_t[c]));
         chk(ev_mem === x_ev_m[c], "R6", "even mem flag", longint'(ev_mem), longint'(x_ev_m[c]));
      end
      if (od_vld && x_od_v[c]) begin
         chk(od_insn === mk(x_od_t[c]), "R10", "odd insn low word", longint'(od_insn[31:0]), longint'(x_od_t[c]));
         chk(od_mem === x_od_m[c], "R6", "odd mem flag", longint'(od_mem), longint'(x_od_m[c]));
      end
   endtask

   task automatic put(input int c, input logic pipe, input int tag, input logic mem);
      if (pipe == 1'b0) begin
         x_ev_v[c] = 1'b1; x_ev_t[c] = tag; x_ev_m[c] = mem;
      end else begin
         x_od_v[c] = 1'b1; x_od_t[c] = tag; x_od_m[c] = mem;
      end
   endtask

   initial begin
      logic [31:0] rs;
      logic m0, m1, mo0, mp0, mp1, mm0, mm1;
      int   mt0, mt1, p;
      logic g0, g1, fit, rdy;
      logic [5:0] combo;

      for (int i = 0; i < NCYC+LAT+1; i++) begin
         x_ev_v[i] = 1'b0; x_ev_m[i] = 1'b0; x_ev_t[i] = 0;
         x_od_v[i] = 1'b0; x_od_m[i] = 1'b0; x_od_t[i] = 0;
         x_req[i]  = "R9";
      end
      rs = 32'h1234_5678;
      m0 = 1'b0; m1 = 1'b0; mo0 = 1'b0; mp0 = 1'b0; mp1 = 1'b0; mm0 = 1'b0; mm1 = 1'b0;
      mt0 = 0; mt1 = 0; p = 0;

      rst_n = 1'b0; pair_valid = 1'b0; ls_avail = 1'b0; hz_stall = 1'b0;
      s0_vld = 1'b0; s0_pipe = 1'b0; s0_mem = 1'b0; s0_insn = '0;
      s1_vld = 1'b0; s1_pipe = 1'b0; s1_mem = 1'b0; s1_insn = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11 reset state
      chk(ev_vld === 1'b0, "R11", "even valid after reset", longint'(ev_vld), 0);
      chk(od_vld === 1'b0, "R11", "odd valid after reset", longint'(od_vld), 0);
      chk(pair_ready === 1'b1, "R11", "ready after reset", longint'(pair_ready), 1);

      for (int c = 0; c < NCYC; c++) begin
         port_chk(c);

         rs = nx(rs);
         if (p < 64) combo = 6'(p);
         else        combo = rs[5:0] | {rs[16], 2'b00, rs[17], 2'b00};
         pair_valid = (c < 400) ? 1'b1 : (rs[12:10] != 3'd0);
         hz_stall   = (c < 150) ? 1'b0 : (rs[14:13] == 2'd0);
         ls_avail   = (c < 150) ? 1'b1 : rs[15];
         s0_vld  = combo[0]; s0_pipe = combo[1]; s0_mem = combo[2];
         s1_vld  = combo[3]; s1_pipe = combo[4]; s1_mem = combo[5];
         s0_insn = mk(2*p);
         s1_insn = mk(2*p + 1);
         #1;

         // reference: pairing rules straight from the requirements
         fit = (mp0 == 1'b0) && (mp1 == 1'b1) && !(mm0 && mm1);
         g0  = m0 && !hz_stall && (!mm0 || ls_avail);
         g1  = m1 && !hz_stall && (!mm1 || ls_avail) && (m0 ? (g0 && fit) : 1'b1);
         rdy = (!m0 || g0) && (!m1 || g1);
         chk(pair_ready === rdy, "R1", "pair_ready", longint'(pair_ready), longint'(rdy));

         if (g0) put(c + LAT, mp0, mt0, mm0);
         if (g1) put(c + LAT, mp1, mt1, mm1);
         if (g0 && g1)                       x_req[c+LAT] = "R2";
         else if (g0 && m1)                  x_req[c+LAT] = "R3";
         else if (g1 && !mo0)                x_req[c+LAT] = "R5";
         else if (g1)                        x_req[c+LAT] = "R4";
         else if (hz_stall && (m0 || m1))    x_req[c+LAT] = "R8";
         else if (m0 && m1 && mm0)           x_req[c+LAT] = "R7";
         else if (m0 || m1)                  x_req[c+LAT] = "R6";

         if (g0) m0 = 1'b0;
         if (g1) m1 = 1'b0;
         if (pair_valid && rdy) begin
            m0 = s0_vld; m1 = s1_vld; mo0 = s0_vld;
            mp0 = s0_pipe; mp1 = s1_pipe; mm0 = s0_mem; mm1 = s1_mem;
            mt0 = 2*p; mt1 = 2*p + 1;
            p++;
         end
         @(negedge clk);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule